// File: doc/BRIEF.md
# Two-Phase Accumulator Micro-Operation Unit

This unit carries out the register-operate class of instructions on a 12-bit accumulator and its one-bit link. The low nine bits of the instruction word are separate enable bits. The unit applies them in two fixed phases inside a single instruction. Clears and complements run in the first phase. Increment and rotations run in the second phase. This order lets one instruction do work such as a two's-complement negate.

Bit 8 of the word picks the group. With bit 8 low, the accumulator group changes the accumulator and the link. With bit 8 high, the skip group tests the incoming accumulator and link and raises a skip request, which the core uses to step over the next instruction. The skip group can also clear the accumulator after the test. The core pulses `start` with the word and the operands, then reads the results when `done` pulses.

Top module: `acc_uop_unit`

## Requirements
- R1: While reset is asserted and after it is released, `ac_out`, `link_out`, `skip` and `done` are all 0.
- R2: A `start` is accepted when the unit is idle. `done` is a one-cycle pulse two cycles after the cycle in which `start` was high. A `start` in the cycle right after an accepted one is ignored and produces no second `done`.
- R3: After `done`, `ac_out`, `link_out` and `skip` keep their values until the next accepted `start`, whatever the other inputs do.
- R4: In the accumulator group (instr[8]=0), phase 1 runs in this order. Bit 7 clears the AC and bit 6 clears the link. Then bit 5 complements the AC and bit 4 complements the link.
- R5: In phase 2 of the accumulator group, bit 0 increments the AC first. A carry out of AC bit 11 complements the link.
- R6: After the increment, bit 2 rotates the 13-bit value {link, AC} left by one and bit 3 rotates it right by one. Bit 1 doubles the rotation to two places. If bits 2 and 3 are both set, there is no rotation. Bit 1 alone has no effect.
- R7: Setting bits 5 and 0 together gives the two's-complement negate of the AC in one instruction. Negating 0 gives 0 and flips the link.
- R8: In the skip group (instr[8]=1), bit 6 tests AC[11]=1, bit 5 tests AC==0 and bit 4 tests link=1, all on the operands given with `start`. `skip` is the OR of the selected tests, inverted when bit 3 is set. In the accumulator group `skip` is 0.
- R9: In the skip group, bit 7 clears the AC after the test. The link is never changed, and bits 2..0 have no effect.
- R10: Instruction bits 11..9 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction using the inputs of this cycle |
| instr | input | 12 | Instruction word |
| ac_in | input | 12 | Accumulator operand |
| link_in | input | 1 | Link operand |
| ac_out | output | 12 | Resulting accumulator |
| link_out | output | 1 | Resulting link |
| skip | output | 1 | Skip request for the next instruction |
| done | output | 1 | One-cycle result-ready pulse |

## Verification
The hardest cases to reach are those where the phase order matters inside one word. These are an increment whose carry flips the link just before a rotation moves that link into the AC, and the cancelling or doubling of rotation bits. The vector table targets these with operands at the carry boundary (all ones, zero, and values with bit 11 or bit 0 set). A second `start` held high into the busy cycle shows that a start is ignored while the unit is busy. Holding changed operands without a start shows that the outputs stay fixed between instructions.

// File: rtl/acc_uop_pkg.sv
package acc_uop_pkg;
  parameter int AC_W = 12;
  localparam int LA_W = AC_W + 1;

  typedef struct packed {
    logic grp_skip;
    logic a_clr_ac;
    logic a_clr_lk;
    logic a_cmp_ac;
    logic a_cmp_lk;
    logic a_rot_r;
    logic a_rot_l;
    logic a_twice;
    logic a_inc;
    logic s_neg;
    logic s_zero;
    logic s_link;
    logic s_sense;
    logic s_clr_ac;
  } uop_t;

  function automatic logic [LA_W-1:0] rot_left(input logic [LA_W-1:0] v);
    return {v[LA_W-2:0], v[LA_W-1]};
  endfunction

  function automatic logic [LA_W-1:0] rot_right(input logic [LA_W-1:0] v);
    return {v[0], v[LA_W-1:1]};
  endfunction

  // Returns {link, ac} after phase 1.
  function automatic logic [LA_W-1:0] phase1_fn(input logic [AC_W-1:0] ac,
                                                 input logic lk, input uop_t u);
    logic [AC_W-1:0] a;
    logic l;
    a = u.a_clr_ac ? '0 : ac;
    l = u.a_clr_lk ? 1'b0 : lk;
    if (u.a_cmp_ac) a = ~a;
    if (u.a_cmp_lk) l = ~l;
    return {l, a};
  endfunction

  // Returns {link, ac} after phase 2.
  function automatic logic [LA_W-1:0] phase2_fn(input logic [AC_W-1:0] ac,
                                                 input logic lk, input uop_t u);
    logic [AC_W:0] sum;
    logic [LA_W-1:0] v;
    v = {lk, ac};
    if (u.a_inc) begin
      sum = {1'b0, ac} + {{AC_W{1'b0}}, 1'b1};
      v = {lk ^ sum[AC_W], sum[AC_W-1:0]};
    end
    if (u.a_rot_l && !u.a_rot_r) begin
      v = rot_left(v);
      if (u.a_twice) v = rot_left(v);
    end else if (u.a_rot_r && !u.a_rot_l) begin
      v = rot_right(v);
      if (u.a_twice) v = rot_right(v);
    end
    if (u.s_clr_ac) v[AC_W-1:0] = '0;
    return v;
  endfunction

  function automatic logic skip_fn(input logic [AC_W-1:0] ac, input logic lk,
                                   input uop_t u);
    logic any;
    any = (u.s_neg && ac[AC_W-1]) || (u.s_zero && (ac == '0)) || (u.s_link && lk);
    return u.grp_skip && (any ^ u.s_sense);
  endfunction
endpackage

// File: rtl/uop_decode.sv
module uop_decode
  import acc_uop_pkg::*;
(
  input  logic [8:0] op_bits,
  output uop_t       uop
);
  logic grp;
  assign grp = op_bits[8];

  always_comb begin
    uop          = '0;
    uop.grp_skip = grp;
    uop.a_clr_ac = !grp && op_bits[7];
    uop.a_clr_lk = !grp && op_bits[6];
    uop.a_cmp_ac = !grp && op_bits[5];
    uop.a_cmp_lk = !grp && op_bits[4];
    uop.a_rot_r  = !grp && op_bits[3];
    uop.a_rot_l  = !grp && op_bits[2];
    uop.a_twice  = !grp && op_bits[1];
    uop.a_inc    = !grp && op_bits[0];
    uop.s_clr_ac = grp && op_bits[7];
    uop.s_neg    = grp && op_bits[6];
    uop.s_zero   = grp && op_bits[5];
    uop.s_link   = grp && op_bits[4];
    uop.s_sense  = grp && op_bits[3];
  end
endmodule

// File: rtl/uop_phase1.sv
module uop_phase1
  import acc_uop_pkg::*;
(
  input  logic [AC_W-1:0] ac_i,
  input  logic            lk_i,
  input  uop_t            uop,
  output logic [AC_W-1:0] ac_o,
  output logic            lk_o,
  output logic            skip_o
);
  logic [LA_W-1:0] res;
  assign res    = phase1_fn(ac_i, lk_i, uop);
  assign ac_o   = res[AC_W-1:0];
  assign lk_o   = res[AC_W];
  assign skip_o = skip_fn(ac_i, lk_i, uop);
endmodule

// File: rtl/uop_phase2.sv
module uop_phase2
  import acc_uop_pkg::*;
(
  input  logic [AC_W-1:0] ac_i,
  input  logic            lk_i,
  input  uop_t            uop,
  output logic [AC_W-1:0] ac_o,
  output logic            lk_o
);
  logic [LA_W-1:0] res;
  assign res  = phase2_fn(ac_i, lk_i, uop);
  assign ac_o = res[AC_W-1:0];
  assign lk_o = res[AC_W];
endmodule

// File: rtl/acc_uop_unit.sv
module acc_uop_unit
  import acc_uop_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [11:0]     instr,
  input  logic [AC_W-1:0] ac_in,
  input  logic            link_in,
  output logic [AC_W-1:0] ac_out,
  output logic            link_out,
  output logic            skip,
  output logic            done
);
  uop_t            dec_uop, uop_q;
  logic [AC_W-1:0] p1_ac, p2_ac, ac_q;
  logic            p1_lk, p2_lk, lk_q;
  logic            p1_skip, skip_q;
  logic            busy_q, done_q;

  // Named events for the checker.
  logic accept;
  logic phase2_fire;
  assign accept      = start && !busy_q;
  assign phase2_fire = busy_q;

  uop_decode u_dec (
    .op_bits (instr[8:0]),
    .uop     (dec_uop)
  );

  uop_phase1 u_p1 (
    .ac_i   (ac_in),
    .lk_i   (link_in),
    .uop    (dec_uop),
    .ac_o   (p1_ac),
    .lk_o   (p1_lk),
    .skip_o (p1_skip)
  );

  uop_phase2 u_p2 (
    .ac_i (ac_q),
    .lk_i (lk_q),
    .uop  (uop_q),
    .ac_o (p2_ac),
    .lk_o (p2_lk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_q   <= '0;
      lk_q   <= 1'b0;
      skip_q <= 1'b0;
      uop_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= phase2_fire;
      if (accept) begin
        ac_q   <= p1_ac;
        lk_q   <= p1_lk;
        skip_q <= p1_skip;
        uop_q  <= dec_uop;
        busy_q <= 1'b1;
      end else if (phase2_fire) begin
        ac_q   <= p2_ac;
        lk_q   <= p2_lk;
        busy_q <= 1'b0;
      end
    end
  end

  assign ac_out   = ac_q;
  assign link_out = lk_q;
  assign skip     = skip_q;
  assign done     = done_q;
endmodule

// File: rtl/acc_uop_unit_chk.sv
module acc_uop_unit_chk
  import acc_uop_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            phase2_fire,
  input logic            done,
  input logic            grp_skip,
  input logic [AC_W-1:0] ac_out,
  input logic            link_out,
  input logic            skip
);
  assert_accept_to_phase2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> phase2_fire);

  assert_phase2_to_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase2_fire |=> done);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_blocks_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase2_fire |-> !accept);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !phase2_fire) |=> ($stable(ac_out) && $stable(link_out) && $stable(skip)));

  assert_skip_group_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase2_fire && grp_skip) |=> $stable(link_out));

  assert_acc_group_noskip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase2_fire && !grp_skip) |-> !skip);
endmodule

bind acc_uop_unit acc_uop_unit_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .phase2_fire (phase2_fire),
  .done        (done),
  .grp_skip    (uop_q.grp_skip),
  .ac_out      (ac_out),
  .link_out    (link_out),
  .skip        (skip)
);

// File: tb/test_acc_uop_unit.sv
module test_acc_uop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] ac_in = '0;
  logic        link_in = 1'b0;
  logic [11:0] ac_out;
  logic        link_out, skip, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  acc_uop_unit i_acc_uop_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .ac_in(ac_in),
    .link_in(link_in), .ac_out(ac_out), .link_out(link_out), .skip(skip), .done(done)
  );

  // {instr, ac, link, exp_ac, exp_link, exp_skip, req}
  localparam int NV = 20;
  localparam logic [42:0] VEC [NV] = '{
    {12'h021, 12'h005, 1'b0, 12'hFFB, 1'b0, 1'b0, 4'd7},  // R7 negate
    {12'h021, 12'h000, 1'b0, 12'h000, 1'b1, 1'b0, 4'd7},  // R7 negate zero, carry
    {12'h0E0, 12'h123, 1'b1, 12'hFFF, 1'b0, 1'b0, 4'd4},  // R4 clear then complement
    {12'h050, 12'h321, 1'b1, 12'h321, 1'b1, 1'b0, 4'd4},  // R4 clear link then flip
    {12'h010, 12'h321, 1'b0, 12'h321, 1'b1, 1'b0, 4'd4},  // R4 flip link
    {12'h004, 12'h800, 1'b0, 12'h000, 1'b1, 1'b0, 4'd6},  // R6 rotate left
    {12'h008, 12'h001, 1'b1, 12'h800, 1'b1, 1'b0, 4'd6},  // R6 rotate right
    {12'h006, 12'h401, 1'b0, 12'h004, 1'b1, 1'b0, 4'd6},  // R6 left twice
    {12'h00A, 12'h003, 1'b0, 12'h800, 1'b1, 1'b0, 4'd6},  // R6 right twice
    {12'h00C, 12'h5A5, 1'b1, 12'h5A5, 1'b1, 1'b0, 4'd6},  // R6 both cancel
    {12'h002, 12'h5A5, 1'b0, 12'h5A5, 1'b0, 1'b0, 4'd6},  // R6 twice alone
    {12'h005, 12'hFFF, 1'b0, 12'h001, 1'b0, 1'b0, 4'd5},  // R5 carry then rotate
    {12'h001, 12'hFFF, 1'b1, 12'h000, 1'b0, 1'b0, 4'd5},  // R5 carry flips link
    {12'h140, 12'h800, 1'b0, 12'h800, 1'b0, 1'b1, 4'd8},  // R8 negative
    {12'h120, 12'h001, 1'b0, 12'h001, 1'b0, 1'b0, 4'd8},  // R8 zero false
    {12'h128, 12'h001, 1'b0, 12'h001, 1'b0, 1'b1, 4'd8},  // R8 sense
    {12'h110, 12'h7FF, 1'b1, 12'h7FF, 1'b1, 1'b1, 4'd8},  // R8 link
    {12'h1F0, 12'h000, 1'b0, 12'h000, 1'b0, 1'b1, 4'd9},  // R9 test then clear
    {12'h1C7, 12'h7FF, 1'b1, 12'h000, 1'b1, 1'b0, 4'd9},  // R9 low bits ignored
    {12'hE21, 12'h005, 1'b0, 12'hFFB, 1'b0, 1'b0, 4'd10}  // R10 top bits ignored
  };

  task automatic chk(input string req, input string what, input logic [12:0] act,
                     input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Start at a negedge; sample done two negedges later.
  task automatic run(input logic [11:0] i, input logic [11:0] a, input logic l,
                     output logic [11:0] ra, output logic rl, output logic rs);
    @(negedge clk);
    start = 1'b1; instr = i; ac_in = a; link_in = l;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "done early", {12'h0, done}, 13'h0);
    @(negedge clk);
    chk("R2", "done on time", {12'h0, done}, 13'h1);
    ra = ac_out; rl = link_out; rs = skip;
  endtask

  initial begin
    logic [11:0] ra;
    logic rl, rs;
    repeat (3) @(negedge clk);
    chk("R1", "reset ac/link", {link_out, ac_out}, 13'h0);
    chk("R1", "reset skip/done", {11'h0, skip, done}, 13'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset outputs", {link_out, ac_out}, 13'h0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[k][3:0]);
      run(VEC[k][42:31], VEC[k][30:19], VEC[k][18], ra, rl, rs);
      chk(tag, "ac", {1'b0, ra}, {1'b0, VEC[k][17:6]});
      chk(tag, "link", {12'h0, rl}, {12'h0, VEC[k][5]});
      chk(tag, "skip", {12'h0, rs}, {12'h0, VEC[k][4]});
    end

    // R2: second start during busy cycle is ignored.
    @(negedge clk);
    start = 1'b1; instr = 12'h021; ac_in = 12'h001; link_in = 1'b0;
    @(negedge clk);
    instr = 12'h080; ac_in = 12'h777; link_in = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy start ignored ac", {link_out, ac_out}, {1'b0, 12'hFFF});
    @(negedge clk);
    chk("R2", "no second done", {12'h0, done}, 13'h0);
    chk("R2", "result kept", {link_out, ac_out}, {1'b0, 12'hFFF});

    // R3: outputs hold while inputs change without start.
    run(12'h128, 12'h001, 1'b1, ra, rl, rs);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      instr = 12'h0A5 + k[11:0]; ac_in = 12'h3C3 ^ k[11:0]; link_in = k[0];
    end
    @(negedge clk);
    chk("R3", "hold ac/link", {link_out, ac_out}, {1'b1, 12'h001});
    chk("R3", "hold skip", {12'h0, skip}, 13'h1);
    chk("R2", "done is a pulse", {12'h0, done}, 13'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule